// File: doc/BRIEF.md
# Prescaled Timer/Counter with External Clock

This block is an 8-bit up-counter whose count rate is chosen by a 3-bit source select. The counter can be halted, advanced on every system clock, advanced on one of four divided-down ticks from a free-running prescaler, or advanced by falling or rising edges on an external input. Software can load the counter at any time and read it continuously. When the count wraps it sets a sticky overflow flag.

The external input is only sensed, never driven, so edges on it count whatever the pin's direction elsewhere on the chip. Software can therefore toggle the pin to advance the count on demand. The input passes through a two-flop synchronizer. An edge detector then gives a one-cycle count enable for each matching edge. A load takes priority over a tick in the same cycle. The next tick then advances from the loaded value, so no tick is lost after a load.

Top module: `pscl_timer`

## Requirements
- R1: After reset `count_o` is 0x00 and `ovf_o` is 0.
- R2: With `clk_sel_i` = 3'b000 the counter holds its value, and edges on `ext_pin_i` have no effect.
- R3: With `clk_sel_i` = 3'b001 the counter increments by one on every rising clock edge.
- R4: With `clk_sel_i` = 3'b010, 3'b011, 3'b100 or 3'b101 the counter advances exactly k times in any window of k·N consecutive clock edges, where N is 8, 64, 256 or 1024 respectively.
- R5: With `clk_sel_i` = 3'b111 each rising edge of `ext_pin_i` advances the counter once, and `clk_sel_i` = 3'b110 does the same for each falling edge. The opposite edge has no effect. The new count is visible after the third rising clock edge that follows the pin change.
- R6: When `wr_en_i` is high at a clock edge, the counter takes `wr_data_i`, even if a tick occurs in that cycle. The next tick then increments from the written value.
- R7: A tick while the count is 0xFF wraps the count to 0x00 and sets `ovf_o`. `ovf_o` stays set until it is cleared.
- R8: `ovf_clr_i` high at a clock edge clears `ovf_o`. If a wrap happens in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 3 | Count source select |
| ext_pin_i | input | 1 | External count input, asynchronous |
| wr_en_i | input | 1 | Load strobe for the counter |
| wr_data_i | input | 8 | Load value |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A load or a system-clock tick shows on `count_o` one clock edge after it is sampled. An external edge needs three edges: two in the synchronizer and one for the count update. So the bench first checks one edge early that the count has not moved, then checks one edge later that it has. The divided rates are measured over windows that are whole multiples of the tap period, so the result does not depend on the prescaler's phase. The overflow flag is checked in the cycle after the wrap, and it is checked again after a long idle stretch to confirm that it holds.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  typedef enum logic [2:0] {
    SEL_STOP   = 3'b000,
    SEL_CLK    = 3'b001,
    SEL_DIV8   = 3'b010,
    SEL_DIV64  = 3'b011,
    SEL_DIV256 = 3'b100,
    SEL_DIV1K  = 3'b101,
    SEL_EXT_FE = 3'b110,
    SEL_EXT_RE = 3'b111
  } clk_sel_e;

  localparam int NUM_TAPS = 4;
  // log2 of each divide ratio, in select-code order
  localparam int TAP_LOG [NUM_TAPS] = '{3, 6, 8, 10};
endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler
  import pscl_timer_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int L = TAP_LOG[g];
    assign tap_o[g] = &pre_q[L-1:0];
  end

  // slower taps only fire together with every faster tap
  for (genvar g = 1; g < NUM_TAPS; g++) begin : g_nest
    p_tap_nest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tap_o[g] |-> tap_o[g-1]);
  end

  p_div8_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[0] |=> !tap_o[0]);
endmodule

// File: rtl/pscl_edge_sync.sv
module pscl_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;

  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_fall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  p_edge_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrap;
  assign wrap = tick_i & ~wr_en_i & (count_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (wr_en_i) count_o <= wr_data_i;  // load beats tick
    else if (tick_i)  count_o <= count_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (wrap)      ovf_o <= 1'b1;       // set beats clear
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  p_write_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> count_o == $past(wr_data_i));
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(count_o));
  p_wrap_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && count_o == CNT_MAX) |=> (count_o == '0) && ovf_o);
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  p_ovf_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(tick_i && !wr_en_i && count_o == CNT_MAX)) |=> !ovf_o);
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       clk_sel_i,
  input  logic             ext_pin_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [NUM_TAPS-1:0] tap;
  logic                ext_rise, ext_fall;
  logic                tick;

  pscl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap)
  );

  pscl_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  always_comb begin
    unique case (clk_sel_e'(clk_sel_i))
      SEL_STOP:   tick = 1'b0;
      SEL_CLK:    tick = 1'b1;
      SEL_DIV8:   tick = tap[0];
      SEL_DIV64:  tick = tap[1];
      SEL_DIV256: tick = tap[2];
      SEL_DIV1K:  tick = tap[3];
      SEL_EXT_FE: tick = ext_fall;
      SEL_EXT_RE: tick = ext_rise;
      default:    tick = 1'b0;
    endcase
  end

  pscl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ovf_clr_i (ovf_clr_i),
    .count_o   (count_o),
    .ovf_o     (ovf_o)
  );

  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == SEL_STOP && !wr_en_i) |=> $stable(count_o));
  p_sel_clk_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == SEL_CLK && !wr_en_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));
endmodule

// File: tb/pscl_timer_bench.sv
module pscl_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       pin = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       clr = 1'b0;
  logic [7:0] count;
  logic       ovf;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  pscl_timer u_pscl_timer (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(sel), .ext_pin_i(pin),
    .wr_en_i(wr), .wr_data_i(wdata), .ovf_clr_i(clr),
    .count_o(count), .ovf_o(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    cycles(1);
    wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", count, 0);
    check("R1 ovf", ovf, 0);
  endtask

  task automatic t_stop;
    logic [7:0] c0;
    sel = 3'b000;
    load(8'h5A);
    check("R6 load in stop", count, 8'h5A);
    c0 = count;
    for (int i = 0; i < 6; i++) begin
      pin = ~pin;
      cycles(5);
    end
    cycles(20);
    check("R2 stop hold", count, c0);
  endtask

  task automatic t_clk;
    logic [7:0] c0;
    sel = 3'b001;
    c0 = count;
    cycles(1);
    check("R3 one step", count, 8'(c0 + 1));
    cycles(9);
    check("R3 ten steps", count, 8'(c0 + 10));
    sel = 3'b000;
  endtask

  task automatic t_div(input logic [2:0] s, input int n, input int k, input string req);
    logic [7:0] c0;
    load(8'h00);
    c0 = count;
    sel = s;
    cycles(n * k);
    sel = 3'b000;
    check(req, count, 8'(c0 + k));
  endtask

  task automatic t_ext(input logic rising);
    logic [7:0] c0;
    sel = 3'b000;
    pin = rising ? 1'b0 : 1'b1;
    cycles(5);
    sel = rising ? 3'b111 : 3'b110;
    c0 = count;
    pin = ~pin;
    cycles(2);
    check(rising ? "R5 rise early" : "R5 fall early", count, c0);
    cycles(1);
    check(rising ? "R5 rise counted" : "R5 fall counted", count, 8'(c0 + 1));
    pin = ~pin;
    cycles(6);
    check(rising ? "R5 rise ignores fall" : "R5 fall ignores rise", count, 8'(c0 + 1));
    pin = ~pin;
    cycles(6);
    check(rising ? "R5 rise second" : "R5 fall second", count, 8'(c0 + 2));
    sel = 3'b000;
  endtask

  task automatic t_write_wins;
    sel = 3'b001;
    load(8'h10);
    check("R6 load beats tick", count, 8'h10);
    cycles(1);
    check("R6 next tick from load", count, 8'h11);
    sel = 3'b000;
  endtask

  task automatic t_overflow;
    sel = 3'b000;
    clr = 1'b1; cycles(1); clr = 1'b0;
    load(8'hFE);
    sel = 3'b001;
    cycles(1);
    check("R7 at FF", count, 8'hFF);
    check("R7 no ovf yet", ovf, 0);
    cycles(1);
    sel = 3'b000;
    check("R7 wrap", count, 8'h00);
    check("R7 ovf set", ovf, 1);
    cycles(30);
    check("R7 ovf sticky", ovf, 1);
    clr = 1'b1; cycles(1); clr = 1'b0;
    check("R8 ovf cleared", ovf, 0);
    load(8'hFF);
    sel = 3'b001; clr = 1'b1;
    cycles(1);
    clr = 1'b0; sel = 3'b000;
    check("R8 set wins", ovf, 1);
    check("R8 wrap count", count, 8'h00);
  endtask

  initial begin
    cycles(3);
    t_reset;
    rst_n = 1'b1;
    cycles(2);
    t_reset;
    t_stop;
    t_clk;
    t_div(3'b010, 8, 20, "R4 div8");
    t_div(3'b011, 64, 10, "R4 div64");
    t_div(3'b100, 256, 4, "R4 div256");
    t_div(3'b101, 1024, 2, "R4 div1024");
    t_ext(1'b1);
    t_ext(1'b0);
    t_write_wins;
    t_overflow;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule